// File: doc/BRIEF.md
# Lane-Sliced Vector Register File

This block stores the architectural vector registers of a four-lane vector unit. Each register is spread over four lane banks: element i sits in lane i mod 4, so consecutive elements go to different lanes and all four lanes can work on the same register in the same cycle. Each lane bank is 64 bits wide per row and holds a quarter of every register, 2 KB per lane and 8 KB in total for 32 registers.

The element width is chosen per access, 16, 32 or 64 bits. The storage does not change with the width; only the way a row is cut into elements changes. A 64-bit row of a lane holds one, two or four elements. A register therefore holds 32, 64 or 128 elements. An access addresses one element group: one row in each of the four lanes, which together hold 256 bits of contiguous elements. The block has two independent read ports and one write port. Each port reaches all four lanes, so every lane bank has two reads and one write. Each element of a write has its own mask bit.

Top module: `lane_vrf`

## Requirements
- R1: While rst_n is low, after a clock edge, both read data outputs are zero.
- R2: Width code 0 selects 16-bit elements, code 1 selects 32-bit and code 2 selects 64-bit. Code 3 behaves exactly like code 2.
- R3: At width w, element i of a register is stored in lane i mod 4, at bit offset (i div 4)*w of that lane's 512-bit slice of the register.
- R4: Read data appears on the read data output in the cycle after the read address is presented.
- R5: The two read ports work independently; each can read any register, group and width in the same cycle.
- R6: Mask bit j enables element j of the group. At width w a group has 256/w elements and element j of the port data sits at bits [j*w +: w]. Elements whose mask bit is 0 keep their value, and mask bits at or above 256/w have no effect.
- R7: When wr_en is low, no storage changes, whatever the write data and mask are.
- R8: A read and a write to the same location in the same cycle return the data held before the write.
- R9: All widths share one storage. Data written at one width reads back at another width in the layout given by R3.
- R10: Group g of a register at width w covers elements g*(256/w) through g*(256/w)+256/w-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read data registers |
| rda_reg | input | 5 | Read port A register number |
| rda_grp | input | 3 | Read port A element group |
| rda_wid | input | 2 | Read port A width code |
| rda_data | output | 256 | Read port A elements, one cycle after the address |
| rdb_reg | input | 5 | Read port B register number |
| rdb_grp | input | 3 | Read port B element group |
| rdb_wid | input | 2 | Read port B width code |
| rdb_data | output | 256 | Read port B elements, one cycle after the address |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 5 | Write register number |
| wr_grp | input | 3 | Write element group |
| wr_wid | input | 2 | Write width code |
| wr_data | input | 256 | Write elements, element j at bits [j*w +: w] |
| wr_mask | input | 16 | Per-element write enable |

## Verification
A shadow model stores each lane's slice of each register as a flat bit string and places elements by the offset rule alone. It is driven with random mixes of widths, masks, groups and registers on all three ports. Any error in the lane choice, the row choice or the sub-row position then shows up as misplaced bits. Directed cases target the points the random stream rarely isolates:
- writes at one width read back at another, which separates a correct shared layout from one kept per width;
- all-zero masks and masks set only above the group size;
- width code 3;
- a write with wr_en low but full data and mask;
- a read of the location being written in the same cycle, which must return the old data.

// File: rtl/lane_vrf_pkg.sv
package lane_vrf_pkg;
  localparam int LANES   = 4;
  localparam int ROW_W   = 64;
  localparam int PORT_W  = LANES * ROW_W;
  localparam int MIN_EW  = 16;
  localparam int MASK_W  = PORT_W / MIN_EW;

  typedef logic [LANES-1:0][ROW_W-1:0] lane_rows_t;

  typedef struct packed {
    lane_rows_t rows;
    lane_rows_t bit_en;
  } scatter_t;

  // element width in bits for a width code; code 3 aliases 64
  function automatic int unsigned ew_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 32;
      default: return 64;
    endcase
  endfunction

  // lane rows -> port vector in element order (element j at j*w)
  function automatic logic [PORT_W-1:0] gather(input lane_rows_t rows, input logic [1:0] code);
    logic [PORT_W-1:0] v;
    v = '0;
    case (code)
      2'd0: for (int j = 0; j < PORT_W/16; j++) v[j*16 +: 16] = rows[j%LANES][(j/LANES)*16 +: 16];
      2'd1: for (int j = 0; j < PORT_W/32; j++) v[j*32 +: 32] = rows[j%LANES][(j/LANES)*32 +: 32];
      default: for (int j = 0; j < LANES; j++) v[j*64 +: 64] = rows[j];
    endcase
    return v;
  endfunction

  // port vector and element mask -> lane rows plus per-bit enables
  function automatic scatter_t scatter(input logic [PORT_W-1:0] d, input logic [MASK_W-1:0] m,
                                       input logic [1:0] code);
    scatter_t s;
    s = '0;
    case (code)
      2'd0: for (int j = 0; j < PORT_W/16; j++) begin
        s.rows[j%LANES][(j/LANES)*16 +: 16]   = d[j*16 +: 16];
        s.bit_en[j%LANES][(j/LANES)*16 +: 16] = {16{m[j]}};
      end
      2'd1: for (int j = 0; j < PORT_W/32; j++) begin
        s.rows[j%LANES][(j/LANES)*32 +: 32]   = d[j*32 +: 32];
        s.bit_en[j%LANES][(j/LANES)*32 +: 32] = {32{m[j]}};
      end
      default: for (int j = 0; j < LANES; j++) begin
        s.rows[j]   = d[j*64 +: 64];
        s.bit_en[j] = {64{m[j]}};
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lane_vrf_bank.sv
module lane_vrf_bank #(
  parameter int ROWS = 256,
  parameter int RW   = 64,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rda_addr,
  input  logic [AW-1:0] rdb_addr,
  output logic [RW-1:0] rda_row,
  output logic [RW-1:0] rdb_row,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_bit_en,
  input  logic [RW-1:0] wr_row
);
  logic [RW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (|wr_bit_en)
      mem[wr_addr] <= (mem[wr_addr] & ~wr_bit_en) | (wr_row & wr_bit_en);
  end

  // registered reads sample the array before this edge's write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rda_row <= '0;
      rdb_row <= '0;
    end else begin
      rda_row <= mem[rda_addr];
      rdb_row <= mem[rdb_addr];
    end
  end
endmodule

// File: rtl/lane_vrf_rport.sv
module lane_vrf_rport
  import lane_vrf_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int GRP_AW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_AW-1:0]        rreg,
  input  logic [GRP_AW-1:0]        rgrp,
  input  logic [1:0]               rwid,
  output logic [REG_AW+GRP_AW-1:0] row_addr,
  input  lane_rows_t               rows,
  output logic [PORT_W-1:0]        data
);
  logic [1:0] wid_q;

  assign row_addr = {rreg, rgrp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wid_q <= 2'd0;
    else        wid_q <= rwid;
  end

  assign data = gather(rows, wid_q);
endmodule

// File: rtl/lane_vrf_wport.sv
module lane_vrf_wport
  import lane_vrf_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int GRP_AW = 3
) (
  input  logic                     en,
  input  logic [REG_AW-1:0]        wreg,
  input  logic [GRP_AW-1:0]        wgrp,
  input  logic [1:0]               wwid,
  input  logic [PORT_W-1:0]        wdata,
  input  logic [MASK_W-1:0]        wmask,
  output logic [REG_AW+GRP_AW-1:0] row_addr,
  output lane_rows_t               rows,
  output lane_rows_t               bit_en
);
  scatter_t sc;

  assign row_addr = {wreg, wgrp};
  assign sc       = scatter(wdata, wmask, wwid);
  assign rows     = sc.rows;
  assign bit_en   = en ? sc.bit_en : '0;
endmodule

// File: rtl/lane_vrf.sv
module lane_vrf
  import lane_vrf_pkg::*;
#(
  parameter int NUM_VREGS    = 32,
  parameter int ROWS_PER_REG = 8,
  localparam int REG_AW      = $clog2(NUM_VREGS),
  localparam int GRP_AW      = $clog2(ROWS_PER_REG),
  localparam int BANK_ROWS   = NUM_VREGS * ROWS_PER_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rda_reg,
  input  logic [GRP_AW-1:0] rda_grp,
  input  logic [1:0]        rda_wid,
  output logic [PORT_W-1:0] rda_data,
  input  logic [REG_AW-1:0] rdb_reg,
  input  logic [GRP_AW-1:0] rdb_grp,
  input  logic [1:0]        rdb_wid,
  output logic [PORT_W-1:0] rdb_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_reg,
  input  logic [GRP_AW-1:0] wr_grp,
  input  logic [1:0]        wr_wid,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [MASK_W-1:0] wr_mask
);
  localparam int AW = REG_AW + GRP_AW;

  logic [AW-1:0] rda_addr, rdb_addr, wr_addr;
  lane_rows_t    rda_rows, rdb_rows, wr_rows;
  lane_rows_t    wr_bit_en;

  lane_vrf_rport #(.REG_AW(REG_AW), .GRP_AW(GRP_AW)) u_rpa (
    .clk(clk), .rst_n(rst_n), .rreg(rda_reg), .rgrp(rda_grp), .rwid(rda_wid),
    .row_addr(rda_addr), .rows(rda_rows), .data(rda_data));

  lane_vrf_rport #(.REG_AW(REG_AW), .GRP_AW(GRP_AW)) u_rpb (
    .clk(clk), .rst_n(rst_n), .rreg(rdb_reg), .rgrp(rdb_grp), .rwid(rdb_wid),
    .row_addr(rdb_addr), .rows(rdb_rows), .data(rdb_data));

  lane_vrf_wport #(.REG_AW(REG_AW), .GRP_AW(GRP_AW)) u_wp (
    .en(wr_en), .wreg(wr_reg), .wgrp(wr_grp), .wwid(wr_wid), .wdata(wr_data),
    .wmask(wr_mask), .row_addr(wr_addr), .rows(wr_rows), .bit_en(wr_bit_en));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_vrf_bank #(.ROWS(BANK_ROWS), .RW(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rda_addr(rda_addr), .rdb_addr(rdb_addr),
      .rda_row(rda_rows[l]), .rdb_row(rdb_rows[l]),
      .wr_addr(wr_addr), .wr_bit_en(wr_bit_en[l]), .wr_row(wr_rows[l]));
  end
endmodule

// File: rtl/lane_vrf_chk.sv
module lane_vrf_chk
  import lane_vrf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_wid,
  input logic [MASK_W-1:0] wr_mask,
  input logic [PORT_W-1:0] bit_en
);
  // R7
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> bit_en == '0);

  // R6
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask == '0) |-> bit_en == '0);

  // R6
  w16_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wid == 2'd0) |-> $countones(bit_en) == 16 * $countones(wr_mask));

  // R6
  w32_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wid == 2'd1) |-> $countones(bit_en) == 32 * $countones(wr_mask[7:0]));

  // R2
  w64_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wid[1]) |-> $countones(bit_en) == 64 * $countones(wr_mask[3:0]));
endmodule

bind lane_vrf lane_vrf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wid(wr_wid),
  .wr_mask(wr_mask), .bit_en(wr_bit_en));

// File: tb/sim_lane_vrf.sv
`timescale 1ns/1ps
module sim_lane_vrf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rda_reg = '0, rdb_reg = '0, wr_reg = '0;
  logic [2:0] rda_grp = '0, rdb_grp = '0, wr_grp = '0;
  logic [1:0] rda_wid = '0, rdb_wid = '0, wr_wid = '0;
  logic [255:0] rda_data, rdb_data, wr_data = '0;
  logic [15:0] wr_mask = '0;
  logic wr_en = 1'b0;

  int n_run = 0, n_fail = 0;
  logic [511:0] shadow [4][32];

  always #10 clk = ~clk;

  lane_vrf u0 (.*);

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 32 : 64;
  endfunction

  // expected read: element i at lane i%4, offset (i/4)*w of the slice
  function automatic logic [255:0] model_rd(input logic [4:0] r, input logic [2:0] g, input logic [1:0] c);
    logic [255:0] v = '0;
    int w = wbits(c);
    int n = 256 / w;
    for (int j = 0; j < n; j++) begin
      int i = g * n + j;
      for (int b = 0; b < w; b++) v[j*w + b] = shadow[i%4][r][(i/4)*w + b];
    end
    return v;
  endfunction

  task automatic model_wr(input logic [4:0] r, input logic [2:0] g, input logic [1:0] c,
                          input logic [255:0] d, input logic [15:0] m);
    int w = wbits(c);
    int n = 256 / w;
    for (int j = 0; j < n; j++) begin
      int i = g * n + j;
      if (m[j]) for (int b = 0; b < w; b++) shadow[i%4][r][(i/4)*w + b] = d[j*w + b];
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, expect at following negedge
  task automatic cycle(input bit we, input logic [4:0] wreg, input logic [2:0] wgrp,
                       input logic [1:0] wwid, input logic [255:0] wd, input logic [15:0] wm,
                       input logic [4:0] ra, input logic [2:0] ga, input logic [1:0] wa,
                       input logic [4:0] rb, input logic [2:0] gb, input logic [1:0] wb,
                       input string tag);
    logic [255:0] ea, eb;
    wr_en = we; wr_reg = wreg; wr_grp = wgrp; wr_wid = wwid; wr_data = wd; wr_mask = wm;
    rda_reg = ra; rda_grp = ga; rda_wid = wa;
    rdb_reg = rb; rdb_grp = gb; rdb_wid = wb;
    ea = model_rd(ra, ga, wa);
    eb = model_rd(rb, gb, wb);
    if (we) model_wr(wreg, wgrp, wwid, wd, wm);
    @(negedge clk);
    check({tag, " port A"}, rda_data, ea);
    check({tag, " port B"}, rdb_data, eb);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [255:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check("R1 reset A", rda_data, '0);
    check("R1 reset B", rdb_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill every row at width 64 (R10 groups cover the register)
    for (int r = 0; r < 32; r++)
      for (int g = 0; g < 8; g++)
        cycle(1'b1, 5'(r), 3'(g), 2'd2, rnd256(), 16'hFFFF,
              5'(r), 3'(g), 2'd2, 5'(31 - r), 3'(g), 2'd1, "R10 fill");

    // R3 R9: write at 16 bits, read back at 64 and 32 bits
    d = '0;
    for (int j = 0; j < 16; j++) d[j*16 +: 16] = 16'(16'h1100 + j);
    cycle(1'b1, 5'd1, 3'd0, 2'd0, d, 16'hFFFF, 5'd1, 3'd0, 2'd2, 5'd1, 3'd0, 2'd0, "R3 w16");
    cycle(1'b0, 5'd0, 3'd0, 2'd0, '0, 16'h0, 5'd1, 3'd0, 2'd2, 5'd1, 3'd1, 2'd1, "R9 cross width");
    cycle(1'b0, 5'd0, 3'd0, 2'd0, '0, 16'h0, 5'd1, 3'd0, 2'd0, 5'd1, 3'd0, 2'd1, "R3 readback");

    // R6: zero mask, and mask bits above the group size
    cycle(1'b1, 5'd2, 3'd3, 2'd1, rnd256(), 16'h0000, 5'd2, 3'd3, 2'd1, 5'd2, 3'd3, 2'd2, "R6 zero mask");
    cycle(1'b1, 5'd2, 3'd3, 2'd2, rnd256(), 16'hFFF0, 5'd2, 3'd3, 2'd2, 5'd2, 3'd3, 2'd0, "R6 high mask");
    cycle(1'b1, 5'd2, 3'd3, 2'd0, rnd256(), 16'hA5C3, 5'd2, 3'd3, 2'd0, 5'd2, 3'd3, 2'd2, "R6 partial");
    cycle(1'b0, 5'd0, 3'd0, 2'd0, '0, 16'h0, 5'd2, 3'd3, 2'd0, 5'd2, 3'd3, 2'd2, "R6 readback");

    // R7: disabled write with full data and mask
    cycle(1'b0, 5'd4, 3'd5, 2'd0, rnd256(), 16'hFFFF, 5'd4, 3'd5, 2'd0, 5'd4, 3'd5, 2'd2, "R7 idle");
    cycle(1'b0, 5'd0, 3'd0, 2'd0, '0, 16'h0, 5'd4, 3'd5, 2'd0, 5'd4, 3'd5, 2'd1, "R7 readback");

    // R2: width code 3 acts as 64 bits
    cycle(1'b1, 5'd6, 3'd7, 2'd3, rnd256(), 16'h0005, 5'd6, 3'd7, 2'd3, 5'd6, 3'd7, 2'd2, "R2 code3 write");
    cycle(1'b0, 5'd0, 3'd0, 2'd0, '0, 16'h0, 5'd6, 3'd7, 2'd3, 5'd6, 3'd7, 2'd2, "R2 code3 read");

    // R8 then R4: same-cycle read sees old data, next cycle sees new
    cycle(1'b1, 5'd9, 3'd2, 2'd2, rnd256(), 16'hFFFF, 5'd9, 3'd2, 2'd2, 5'd9, 3'd2, 2'd0, "R8 old data");
    cycle(1'b0, 5'd0, 3'd0, 2'd0, '0, 16'h0, 5'd9, 3'd2, 2'd2, 5'd9, 3'd2, 2'd0, "R4 next cycle");

    // R5 R4 R6 R9: constrained random traffic over all ports
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] wrg = 5'($urandom_range(31));
      logic [2:0] wgp = 3'($urandom_range(7));
      logic same = ($urandom_range(3) == 0);
      cycle(($urandom_range(9) < 7), wrg, wgp, 2'($urandom_range(3)), rnd256(), 16'($urandom),
            same ? wrg : 5'($urandom_range(31)), same ? wgp : 3'($urandom_range(7)), 2'($urandom_range(3)),
            5'($urandom_range(31)), 3'($urandom_range(7)), 2'($urandom_range(3)), "R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule